// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on independent clocks. Words of a parameterised width (nine bits by default) go in on the write clock and come out, in order, on the read clock. The write and read positions cross between the two domains as Gray codes through multi-stage synchronizers. The empty and almost-empty flags are formed in the read domain. The full and almost-full flags are formed in the write domain. All four flags are active low.

The almost-empty and almost-full thresholds are held in two offset registers. After reset these hold parameter defaults, and they can be rewritten through the data input. One write-side pin plays one of two roles, and the role is fixed by the pin's level during reset. If the pin is held high, it is a second write enable. If it is held low, it is a strobe that loads the offset registers.

The read word is held in an output register. An active-low output enable decides whether the word is driven onto the read data port or the port is parked at zero. A separate drive indication shows which case applies, so a pad ring can build a three-state buffer from it.

Top module: `xclk_fifo_pflag`

## Requirements
- R1: While `rst_n` is low, and for the synchronizer stages after it rises, both domains are held in reset with both clocks running. The FIFO is emptied, `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, and the held read word is 0.
- R2: When `out_en_n`=0, `rd_q` shows the held read word and `rd_q_drv`=1. When `out_en_n`=1, `rd_q`=0 and `rd_q_drv`=0.
- R3: Words leave in the order they were written. A read occurs at a read-clock edge where `rd_en1`=1, `rd_en2`=1 and the FIFO is not empty, and the read word changes at that same edge.
- R4: Let the count be the number of stored words as seen by a domain. `empty_n` is low exactly when the read-domain count is 0. `full_n` is low exactly when the write-domain count equals DEPTH (16 by default).
- R5: `aempty_n` is low exactly when the read-domain count is less than or equal to the empty offset. `afull_n` is low exactly when DEPTH minus the write-domain count is less than or equal to the full offset. After reset the offsets are AE_DEFAULT=2 and AF_DEFAULT=3.
- R6: A write while full and a read while empty are ignored. The stored words, the positions and the held read word do not change.
- R7: In dual-enable mode, a word is stored only when `wr_en1`=1 and `wr_en2_ld`=1. In either mode, a read needs both `rd_en1` and `rd_en2`.
- R8: When a word is written into an empty FIFO, `empty_n` is still low after the first read-clock rising edge that follows the write edge. It goes high at the second such edge. The word can then be read on the next read cycle.
- R9: The level of `wr_en2_ld` at the write-clock edges during reset selects the mode: high gives dual-enable mode, low gives load mode. In load mode, `wr_en1`=1 with `wr_en2_ld`=1 loads `wr_data[AW-1:0]` into an offset register and stores no word. The loads alternate between the empty offset and the full offset, starting with the empty offset after each reset. In load mode, `wr_en1`=1 with `wr_en2_ld`=0 stores a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write clock |
| wr_data | input | DW | Write word, or offset value in load mode |
| wr_en1 | input | 1 | Primary write enable, active high |
| wr_en2_ld | input | 1 | Second write enable or offset load strobe, role strapped at reset |
| full_n | output | 1 | Full flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| rd_clk | input | 1 | Read clock |
| rd_en1 | input | 1 | First read enable, active high |
| rd_en2 | input | 1 | Second read enable, active high |
| out_en_n | input | 1 | Output enable, active low |
| rd_q | output | DW | Read word, zero when the output is disabled |
| rd_q_drv | output | 1 | High when `rd_q` is to be driven onto the pads |
| empty_n | output | 1 | Empty flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The read word and the output-enable path respond within the same read cycle. The bench therefore samples `rd_q` at the falling read edge that follows each read request. The flags depend on a position that has crossed domains, so they settle two edges of the observing clock after the other side moves. Before each flag check, the bench waits four edges of each clock and then compares all four flags with a word count kept in the bench. The first-word latency is the one result checked edge by edge: one nanosecond after the first and after the second read-clock edge that follow a write into an empty FIFO. This is repeated over several clock phases.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

   typedef enum logic {
      MODE_DUAL_EN = 1'b0,
      MODE_LOAD    = 1'b1
   } wr_pin_mode_e;

   typedef enum logic {
      SEL_AE = 1'b0,
      SEL_AF = 1'b1
   } ofs_sel_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         arst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xfifo_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) stg <= {STAGES{RST_VAL}};
      else      stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
   parameter int unsigned DW    = 9,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
   import xfifo_pkg::*;
#(
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned AE_DEFAULT = 2,
   parameter int unsigned AF_DEFAULT = 3,
   localparam int unsigned AW        = $clog2(DEPTH),
   localparam int unsigned PW        = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en1,
   input  logic          en2_ld,
   input  logic [AW-1:0] ofs_in,
   input  logic [PW-1:0] rgray_s,
   output logic [PW-1:0] wgray,
   output logic          push,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] ae_ofs,
   output logic          full_n,
   output logic          afull_n
);

   wr_pin_mode_e  mode;
   ofs_sel_e      sel;
   logic [PW-1:0] wbin, wnext, rbin, level, space;
   logic [AW-1:0] af_ofs;
   logic          full, wants_word, do_load;

   always_comb begin
      for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
   end

   assign level   = wbin - rbin;
   assign space   = PW'(DEPTH) - level;
   assign full    = (level == PW'(DEPTH));
   assign full_n  = !full;
   assign afull_n = !(space <= {1'b0, af_ofs});

   assign wants_word = en1 && ((mode == MODE_DUAL_EN) ? en2_ld : !en2_ld);
   assign push       = wants_word && !full;
   assign do_load    = en1 && en2_ld && (mode == MODE_LOAD);
   assign wnext      = wbin + PW'(1);
   assign waddr      = wbin[AW-1:0];

   always_ff @(posedge clk) begin
      if (rst) mode <= en2_ld ? MODE_DUAL_EN : MODE_LOAD;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wbin   <= '0;
         wgray  <= '0;
         ae_ofs <= AW'(AE_DEFAULT);
         af_ofs <= AW'(AF_DEFAULT);
         sel    <= SEL_AE;
      end else begin
         if (push) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
         end
         if (do_load) begin
            if (sel == SEL_AE) ae_ofs <= ofs_in;
            else               af_ofs <= ofs_in;
            sel <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
         end
      end
   end

endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl #(
   parameter int unsigned DW    = 9,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned PW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en1,
   input  logic          en2,
   input  logic [PW-1:0] wgray_s,
   input  logic [AW-1:0] ae_ofs_s,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic [DW-1:0] word,
   output logic          empty_n,
   output logic          aempty_n
);

   logic [PW-1:0] rbin, rnext, wbin, level;
   logic          empty, pop;

   always_comb begin
      for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
   end

   assign level    = wbin - rbin;
   assign empty    = (level == '0);
   assign empty_n  = !empty;
   assign aempty_n = !(level <= {1'b0, ae_ofs_s});
   assign pop      = en1 && en2 && !empty;
   assign rnext    = rbin + PW'(1);
   assign raddr    = rbin[AW-1:0];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rbin  <= '0;
         rgray <= '0;
         word  <= '0;
      end else if (pop) begin
         rbin  <= rnext;
         rgray <= rnext ^ (rnext >> 1);
         word  <= rdata;
      end
   end

endmodule

// File: rtl/xclk_fifo_pflag.sv
module xclk_fifo_pflag #(
   parameter int unsigned DW          = 9,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AE_DEFAULT  = 2,
   parameter int unsigned AF_DEFAULT  = 3
) (
   input  logic          rst_n,
   input  logic          wr_clk,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_en1,
   input  logic          wr_en2_ld,
   output logic          full_n,
   output logic          afull_n,
   input  logic          rd_clk,
   input  logic          rd_en1,
   input  logic          rd_en2,
   input  logic          out_en_n,
   output logic [DW-1:0] rd_q,
   output logic          rd_q_drv,
   output logic          empty_n,
   output logic          aempty_n
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;

   if (!xfifo_pkg::is_pow2(DEPTH) || DEPTH < 4) begin : g_bad_depth
      $error("xclk_fifo_pflag: DEPTH must be a power of two, at least 4");
   end
   if (AE_DEFAULT >= DEPTH || AF_DEFAULT >= DEPTH) begin : g_bad_ofs
      $error("xclk_fifo_pflag: default offsets must be below DEPTH");
   end
   if (DW < AW) begin : g_bad_dw
      $error("xclk_fifo_pflag: DW must hold an offset value");
   end

   logic          arst, wr_alive, rd_alive, wrst, rrst, push;
   logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
   logic [AW-1:0] waddr, raddr, ae_ofs, ae_ofs_s;
   logic [DW-1:0] rdata, rd_word;

   assign arst = !rst_n;

   xfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wrst (
      .clk(wr_clk), .arst(arst), .d(1'b1), .q(wr_alive));
   xfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rrst (
      .clk(rd_clk), .arst(arst), .d(1'b1), .q(rd_alive));

   assign wrst = !wr_alive;
   assign rrst = !rd_alive;

   xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .arst(wrst), .d(rgray), .q(rgray_s));
   xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .arst(rrst), .d(wgray), .q(wgray_s));
   xfifo_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL(AW'(AE_DEFAULT))) u_ofs (
      .clk(rd_clk), .arst(rrst), .d(ae_ofs), .q(ae_ofs_s));

   xfifo_wr_ctl #(.DEPTH(DEPTH), .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)) u_wr (
      .clk(wr_clk), .rst(wrst), .en1(wr_en1), .en2_ld(wr_en2_ld),
      .ofs_in(wr_data[AW-1:0]), .rgray_s(rgray_s), .wgray(wgray), .push(push),
      .waddr(waddr), .ae_ofs(ae_ofs), .full_n(full_n), .afull_n(afull_n));

   xfifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(rdata));

   xfifo_rd_ctl #(.DW(DW), .DEPTH(DEPTH)) u_rd (
      .clk(rd_clk), .rst(rrst), .en1(rd_en1), .en2(rd_en2),
      .wgray_s(wgray_s), .ae_ofs_s(ae_ofs_s), .rdata(rdata), .raddr(raddr),
      .rgray(rgray), .word(rd_word), .empty_n(empty_n), .aempty_n(aempty_n));

   assign rd_q     = out_en_n ? '0 : rd_word;
   assign rd_q_drv = !out_en_n;

endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk #(
   parameter int unsigned DW = 9,
   parameter int unsigned PW = 5
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          wrst,
   input logic          rrst,
   input logic          wr_en1,
   input logic          rd_en1,
   input logic          rd_en2,
   input logic          out_en_n,
   input logic [PW-1:0] wgray,
   input logic [PW-1:0] rgray,
   input logic [DW-1:0] rd_q,
   input logic          rd_q_drv,
   input logic          full_n,
   input logic          afull_n,
   input logic          empty_n,
   input logic          aempty_n
);

   AST_RESET_WR_FLAGS: assert property (@(posedge wr_clk) wrst |-> (full_n && afull_n)); // R1
   AST_RESET_RD_FLAGS: assert property (@(posedge rd_clk) rrst |-> (!empty_n && !aempty_n)); // R1
   AST_OE_PARKED: assert property (@(posedge rd_clk) out_en_n |-> (rd_q == '0 && !rd_q_drv)); // R2
   AST_RD_STEP_ONE_BIT: assert property (@(posedge rd_clk) disable iff (rrst) 1'b1 |=> $onehot0(rgray ^ $past(rgray))); // R3
   AST_WR_STEP_ONE_BIT: assert property (@(posedge wr_clk) disable iff (wrst) 1'b1 |=> $onehot0(wgray ^ $past(wgray))); // R4
   AST_EMPTY_IN_AEMPTY: assert property (@(posedge rd_clk) disable iff (rrst) !empty_n |-> !aempty_n); // R5
   AST_FULL_IN_AFULL: assert property (@(posedge wr_clk) disable iff (wrst) !full_n |-> !afull_n); // R5
   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wrst) !full_n |=> $stable(wgray)); // R6
   AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rrst) !empty_n |=> $stable(rgray)); // R6
   AST_WR_NEEDS_EN1: assert property (@(posedge wr_clk) disable iff (wrst) !wr_en1 |=> $stable(wgray)); // R7
   AST_RD_NEEDS_BOTH: assert property (@(posedge rd_clk) disable iff (rrst) !(rd_en1 && rd_en2) |=> $stable(rgray)); // R7

endmodule

bind xclk_fifo_pflag xfifo_chk #(.DW(DW), .PW(PW)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst(wrst), .rrst(rrst),
   .wr_en1(wr_en1), .rd_en1(rd_en1), .rd_en2(rd_en2), .out_en_n(out_en_n),
   .wgray(wgray), .rgray(rgray), .rd_q(rd_q), .rd_q_drv(rd_q_drv),
   .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n));

// File: tb/sim_xclk_fifo_pflag.sv
`timescale 1ns/1ps
module sim_xclk_fifo_pflag;

   localparam int DW = 9;
   localparam int DEPTH = 16;

   logic          rst_n, wr_clk, rd_clk;
   logic [DW-1:0] wr_data;
   logic          wr_en1, wr_en2_ld, rd_en1, rd_en2, out_en_n;
   logic [DW-1:0] rd_q;
   logic          rd_q_drv, full_n, afull_n, empty_n, aempty_n;

   int nchk = 0;
   int nerr = 0;
   bit load_mode = 0;
   int cur_ae = 2;
   int cur_af = 3;
   logic [DW-1:0] got;

   xclk_fifo_pflag u0 (
      .rst_n(rst_n), .wr_clk(wr_clk), .wr_data(wr_data), .wr_en1(wr_en1),
      .wr_en2_ld(wr_en2_ld), .full_n(full_n), .afull_n(afull_n),
      .rd_clk(rd_clk), .rd_en1(rd_en1), .rd_en2(rd_en2), .out_en_n(out_en_n),
      .rd_q(rd_q), .rd_q_drv(rd_q_drv), .empty_n(empty_n), .aempty_n(aempty_n));

   // 100 MHz write clock: rising edges at 5, 15, 25 ...
   initial begin
      wr_clk = 0;
      forever #5 wr_clk = ~wr_clk;
   end

   // read clock: rising edges at 2 + 16k, never on a write edge
   initial begin
      rd_clk = 0;
      #2;
      forever begin
         rd_clk = 1; #8;
         rd_clk = 0; #8;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle_wr2();
      wr_en2_ld = load_mode ? 1'b0 : 1'b1;
   endtask

   task automatic settle();
      repeat (4) @(negedge rd_clk);
      repeat (4) @(negedge wr_clk);
   endtask

   task automatic do_reset(input bit strap_low);
      load_mode = strap_low;
      rst_n = 0;
      wr_en1 = 0; rd_en1 = 0; rd_en2 = 0;
      idle_wr2();
      repeat (3) @(negedge wr_clk);
      rst_n = 1;
      repeat (4) @(negedge wr_clk);
      settle();
      cur_ae = 2;
      cur_af = 3;
   endtask

   task automatic push(input logic [DW-1:0] d);
      @(negedge wr_clk);
      wr_data = d; wr_en1 = 1;
      idle_wr2();
      @(negedge wr_clk);
      wr_en1 = 0;
   endtask

   task automatic load_ofs(input int v);
      @(negedge wr_clk);
      wr_data = DW'(v); wr_en1 = 1; wr_en2_ld = 1;
      @(negedge wr_clk);
      wr_en1 = 0;
      idle_wr2();
   endtask

   task automatic pop(output logic [DW-1:0] v);
      @(negedge rd_clk);
      rd_en1 = 1; rd_en2 = 1;
      @(negedge rd_clk);
      rd_en1 = 0; rd_en2 = 0;
      v = rd_q;
   endtask

   task automatic check_flags(input int cnt, input string tag);
      chk({tag, " R4 empty_n"}, int'(empty_n), (cnt == 0) ? 0 : 1);
      chk({tag, " R4 full_n"}, int'(full_n), (cnt == DEPTH) ? 0 : 1);
      chk({tag, " R5 aempty_n"}, int'(aempty_n), (cnt <= cur_ae) ? 0 : 1);
      chk({tag, " R5 afull_n"}, int'(afull_n), ((DEPTH - cnt) <= cur_af) ? 0 : 1);
   endtask

   function automatic logic [DW-1:0] pat(input int k, input int seed);
      return DW'((k * 37 + seed) % 512);
   endfunction

   task automatic fill_drain(input int seed, input string tag);
      for (int k = 0; k < DEPTH; k++) begin
         push(pat(k, seed));
         settle();
         check_flags(k + 1, {tag, " fill"});
      end
      push(9'h1AA);                          // R6 write while full
      settle();
      check_flags(DEPTH, {tag, " R6 overfull"});
      for (int k = 0; k < DEPTH; k++) begin
         pop(got);
         chk({tag, " R3 order"}, int'(got), int'(pat(k, seed)));
         settle();
         check_flags(DEPTH - 1 - k, {tag, " drain"});
      end
   endtask

   initial begin
      rst_n = 0; wr_data = '0; wr_en1 = 0; wr_en2_ld = 1;
      rd_en1 = 0; rd_en2 = 0; out_en_n = 0;

      // R1 / R2: flags and output during reset
      repeat (2) @(negedge wr_clk);
      chk("R1 empty_n in reset", int'(empty_n), 0);
      chk("R1 aempty_n in reset", int'(aempty_n), 0);
      chk("R1 full_n in reset", int'(full_n), 1);
      chk("R1 afull_n in reset", int'(afull_n), 1);
      chk("R2 rd_q zero after reset", int'(rd_q), 0);
      chk("R2 rd_q_drv enabled", int'(rd_q_drv), 1);
      out_en_n = 1; #1;
      chk("R2 rd_q_drv disabled", int'(rd_q_drv), 0);
      out_en_n = 0;

      do_reset(0);
      check_flags(0, "R1 after reset");

      // main sweep, default offsets
      fill_drain(5, "dual");

      // R6 read while empty leaves word and position
      pop(got);
      chk("R6 empty read keeps word", int'(got), int'(pat(DEPTH - 1, 5)));
      push(9'h055);
      settle();
      pop(got);
      chk("R6 no position slip", int'(got), 'h055);

      // R2 output enable while holding data
      out_en_n = 1; #1;
      chk("R2 parked rd_q", int'(rd_q), 0);
      chk("R2 parked drv", int'(rd_q_drv), 0);
      out_en_n = 0; #1;
      chk("R2 shown rd_q", int'(rd_q), 'h055);

      // R7 both write enables needed
      @(negedge wr_clk); wr_data = 9'h0F0; wr_en1 = 1; wr_en2_ld = 0;
      @(negedge wr_clk); wr_en1 = 0; wr_en2_ld = 1;
      settle();
      chk("R7 wr_en1 alone", int'(empty_n), 0);
      push(9'h0F1);
      settle();
      @(negedge rd_clk); rd_en1 = 1; rd_en2 = 0;
      @(negedge rd_clk); rd_en1 = 0;
      chk("R7 rd_en1 alone word", int'(rd_q), 'h055);
      settle();
      chk("R7 rd_en1 alone count", int'(empty_n), 1);
      pop(got);
      chk("R7 stored word", int'(got), 'h0F1);
      settle();
      chk("R7 drained", int'(empty_n), 0);

      // R8 first-word latency over several phases
      for (int i = 0; i < 5; i++) begin
         repeat (i + 1) @(negedge rd_clk);
         @(negedge wr_clk);
         wr_data = DW'(9'h100 + i); wr_en1 = 1; wr_en2_ld = 1;
         @(posedge wr_clk); #1;
         wr_en1 = 0;
         @(posedge rd_clk); #1;
         chk("R8 still empty after edge one", int'(empty_n), 0);
         @(posedge rd_clk); #1;
         chk("R8 not empty after edge two", int'(empty_n), 1);
         pop(got);
         chk("R8 first word", int'(got), 'h100 + i);
         settle();
      end

      // R1 reset while holding words, clocks running
      push(9'h011); push(9'h022); push(9'h033);
      settle();
      check_flags(3, "R1 pre");
      rst_n = 0;
      @(negedge wr_clk);
      chk("R1 mid reset empty_n", int'(empty_n), 0);
      chk("R1 mid reset full_n", int'(full_n), 1);
      chk("R1 mid reset word", int'(rd_q), 0);
      do_reset(0);
      check_flags(0, "R1 post");

      // R9 load mode
      do_reset(1);
      load_ofs(5);
      load_ofs(6);
      cur_ae = 5;
      cur_af = 6;
      settle();
      chk("R9 load stores no word", int'(empty_n), 0);
      fill_drain(11, "R9 load");
      load_ofs(1);                           // back to the empty offset
      cur_ae = 1;
      push(9'h0AB); push(9'h0CD);
      settle();
      check_flags(2, "R9 alternate");
      pop(got);
      chk("R9 word order", int'(got), 'h0AB);
      pop(got);
      chk("R9 word order", int'(got), 'h0CD);

      // R9 strap high again restores defaults and dual enables
      do_reset(0);
      @(negedge wr_clk); wr_data = 9'h007; wr_en1 = 1; wr_en2_ld = 0;
      @(negedge wr_clk); wr_en1 = 0; wr_en2_ld = 1;
      settle();
      chk("R9 dual mode needs second enable", int'(empty_n), 0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge wr_clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule